// File: doc/BRIEF.md
# Sample-Rate Active and Reactive Power Averager

This block receives one signed voltage sample and one signed current sample per sample period, marked by a valid strobe. For every valid sample it forms two products. The active product is voltage times current. The quadrature product is current times a phase-shifted voltage, and that voltage comes from a leaky first-order integrator whose gain is scaled by an epsilon word so that the integrator's dependence on line frequency can be trimmed out. Both products are summed over an interval of N valid samples, where N is a power of two. At the close of the interval the sums are divided by N with an arithmetic shift.

When an interval ends, the block updates its result registers in a single step. The registers take the mean active power plus a signed user offset, the mean reactive power, and the largest voltage magnitude and largest current magnitude seen in that interval. A one-clock ready pulse accompanies the update. The offset lets a system cancel a no-load reading: it reads the active result at no load and writes back its negation.

Top module: `pwr_accum_engine`

## Requirements
- R1: A synchronous reset clears the integrator, both sums, the sample counter, the peak trackers, all four result outputs and `res_rdy`. The first interval after reset begins at the next valid sample.
- R2: `avg_p` equals floor(sum of v*i over the interval / N) + `p_offset`. The floor comes from an arithmetic right shift, so it rounds toward minus infinity.
- R3: N = 2^`n_log2`, and any `n_log2` above 12 is treated as 12. The value is taken at the first valid sample of an interval, so a change made during an interval applies from the next interval. N = 1 gives a result on every valid sample.
- R4: On each valid sample the integrator state updates as s = s + v - (s >>> 4). The quadrature voltage is (s * eps) >>> 15, where s is the updated state and `eps` is unsigned with 15 fraction bits (0x8000 means 1.0). The integrator state is never cleared at an interval boundary.
- R5: `avg_q` equals floor(sum of i*vq over the interval / N).
- R6: `v_peak` and `i_peak` hold the largest absolute sample value of the interval as an unsigned number, and the sample -32768 reads as 32768.
- R7: `res_rdy` is high for exactly the one clock after the edge that takes the N-th valid sample. The result outputs change only in that clock and hold their values otherwise.
- R8: Clocks without `smp_vld` change neither the counter, the sums, the peaks nor the integrator.
- R9: Sums and peak trackers restart from zero at each boundary, so a result depends only on the samples of its own interval.
- R10: The `p_offset` value added is the one present at the edge that takes the final sample of the interval.
- R11: Sums do not overflow. 4096 samples of (-32768, -32768) give `avg_p` = 2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample valid strobe |
| v_smp | input | 16 | Signed voltage sample |
| i_smp | input | 16 | Signed current sample |
| n_log2 | input | 4 | log2 of interval length N |
| eps | input | 16 | Unsigned integrator gain trim, 1.15 fixed point |
| p_offset | input | 32 | Signed offset added to mean active power |
| avg_p | output | 33 | Signed mean active power plus offset |
| avg_q | output | 38 | Signed mean reactive power |
| v_peak | output | 16 | Largest voltage magnitude of last interval |
| i_peak | output | 16 | Largest current magnitude of last interval |
| res_rdy | output | 1 | One-clock result update pulse |

## Verification
The first stimulus is a table of eight mixed-sign samples that includes both full-scale extremes. It checks the sign handling of each product, the floor rounding of the shift and the magnitude of -32768 in the peak trackers. A second interval uses a different epsilon, idle clocks between samples and an offset changed just before the last sample. This separates the gain trim, the hold behaviour and the moment at which the offset is sampled. Changes of N in the middle of an interval, N = 1, a 4096-sample full-scale run and a reset in the middle of an interval show whether N is latched at the right point, whether the sums are wide enough and whether the integrator state carries over between intervals.

// File: rtl/pae_pkg.sv
package pae_pkg;
    // integrator leak as a right shift of its own state
    localparam int PAE_LEAK_SH  = 4;
    // fraction bits of the epsilon gain trim
    localparam int PAE_EPS_FRAC = 15;
    // largest supported log2 of the interval length
    localparam int PAE_MAX_LOG2N = 12;
endpackage

// File: rtl/pae_quad_gen.sv
module pae_quad_gen #(
    parameter int SMP_W    = 16,
    parameter int EPS_W    = 16,
    parameter int LEAK_SH  = pae_pkg::PAE_LEAK_SH,
    parameter int EPS_FRAC = pae_pkg::PAE_EPS_FRAC,
    localparam int INT_W   = SMP_W + LEAK_SH + 1,
    localparam int VQ_W    = INT_W + EPS_W - EPS_FRAC,
    localparam int MUL_W   = INT_W + EPS_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] v_smp,
    input  logic [EPS_W-1:0]        eps,
    output logic signed [VQ_W-1:0]  vq
);
    typedef struct packed {
        logic signed [INT_W-1:0] integ;
    } qg_state_t;

    qg_state_t st_d, st_q;
    logic signed [INT_W-1:0] integ_nxt;
    logic signed [MUL_W-1:0] scaled;

    always_comb begin
        st_d      = st_q;
        integ_nxt = st_q.integ + INT_W'(v_smp) - (st_q.integ >>> LEAK_SH);
        if (smp_vld) begin
            st_d.integ = integ_nxt;
        end
        scaled = MUL_W'(integ_nxt) * $signed(MUL_W'({1'b0, eps}));
        vq     = VQ_W'(scaled >>> EPS_FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R8: integrator only moves on a valid sample
    p_integ_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(st_q.integ));
endmodule

// File: rtl/pae_accum.sv
module pae_accum #(
    parameter int IN_W  = 32,
    parameter int ACC_W = 44
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    add_vld,
    input  logic                    close,
    input  logic signed [IN_W-1:0]  term,
    output logic signed [ACC_W-1:0] total
);
    logic signed [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        total = acc_q + ACC_W'(term);
        acc_d = acc_q;
        if (add_vld) begin
            acc_d = close ? '0 : total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    // R8: idle clocks leave the running sum alone
    p_acc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !add_vld |=> $stable(acc_q));
endmodule

// File: rtl/pae_peak.sv
module pae_peak #(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld,
    input  logic                    close,
    input  logic signed [SMP_W-1:0] smp,
    output logic [SMP_W-1:0]        pk_total
);
    logic [SMP_W-1:0] pk_d, pk_q;
    logic signed [SMP_W:0] ext;
    logic [SMP_W-1:0] mag;

    always_comb begin
        ext      = (SMP_W+1)'(smp);
        mag      = SMP_W'(smp[SMP_W-1] ? -ext : ext);
        pk_total = (vld && (mag > pk_q)) ? mag : pk_q;
        pk_d     = pk_q;
        if (vld) begin
            pk_d = close ? '0 : pk_total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pk_q <= '0;
        else     pk_q <= pk_d;
    end

    // R6: within an interval the tracked peak never falls
    p_peak_mono_r6: assert property (@(posedge clk) disable iff (rst)
        (vld && !close) |=> (pk_q >= $past(pk_q)));
endmodule

// File: rtl/pwr_accum_engine.sv
module pwr_accum_engine #(
    parameter int SMP_W     = 16,
    parameter int EPS_W     = 16,
    parameter int MAX_LOG2N = pae_pkg::PAE_MAX_LOG2N,
    localparam int NW       = $clog2(MAX_LOG2N + 1),
    localparam int CNT_W    = (MAX_LOG2N > 0) ? MAX_LOG2N : 1,
    localparam int PROD_W   = 2 * SMP_W,
    localparam int INT_W    = SMP_W + pae_pkg::PAE_LEAK_SH + 1,
    localparam int VQ_W     = INT_W + EPS_W - pae_pkg::PAE_EPS_FRAC,
    localparam int QPROD_W  = SMP_W + VQ_W,
    localparam int PACC_W   = PROD_W + MAX_LOG2N,
    localparam int QACC_W   = QPROD_W + MAX_LOG2N
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_vld,
    input  logic signed [SMP_W-1:0]  v_smp,
    input  logic signed [SMP_W-1:0]  i_smp,
    input  logic [NW-1:0]            n_log2,
    input  logic [EPS_W-1:0]         eps,
    input  logic signed [PROD_W-1:0] p_offset,
    output logic signed [PROD_W:0]   avg_p,
    output logic signed [QPROD_W-1:0] avg_q,
    output logic [SMP_W-1:0]         v_peak,
    output logic [SMP_W-1:0]         i_peak,
    output logic                     res_rdy
);
    typedef struct packed {
        logic [CNT_W-1:0]          cnt;
        logic [NW-1:0]             sh;
        logic signed [PROD_W:0]    avg_p;
        logic signed [QPROD_W-1:0] avg_q;
        logic [SMP_W-1:0]          vpk;
        logic [SMP_W-1:0]          ipk;
        logic                      rdy;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [NW-1:0]             sh_in, sh_eff;
    logic [CNT_W-1:0]          last_idx;
    logic                      close;
    logic signed [PROD_W-1:0]  p_inst;
    logic signed [QPROD_W-1:0] q_inst;
    logic signed [VQ_W-1:0]    vq;
    logic signed [PACC_W-1:0]  p_sum;
    logic signed [QACC_W-1:0]  q_sum;
    logic [SMP_W-1:0]          vpk_tot, ipk_tot;

    // interval length: clamp, and hold it once an interval has started
    always_comb begin
        sh_in    = (n_log2 > NW'(MAX_LOG2N)) ? NW'(MAX_LOG2N) : n_log2;
        sh_eff   = (st_q.cnt == '0) ? sh_in : st_q.sh;
        last_idx = CNT_W'(((CNT_W+1)'(1) << sh_eff) - 1'b1);
        close    = (st_q.cnt == last_idx);
        p_inst   = PROD_W'(v_smp) * PROD_W'(i_smp);
        q_inst   = QPROD_W'(i_smp) * QPROD_W'(vq);
    end

    pae_quad_gen #(.SMP_W(SMP_W), .EPS_W(EPS_W)) u_quad (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .v_smp(v_smp), .eps(eps), .vq(vq)
    );

    pae_accum #(.IN_W(PROD_W), .ACC_W(PACC_W)) u_acc_p (
        .clk(clk), .rst(rst), .add_vld(smp_vld), .close(close),
        .term(p_inst), .total(p_sum)
    );

    pae_accum #(.IN_W(QPROD_W), .ACC_W(QACC_W)) u_acc_q (
        .clk(clk), .rst(rst), .add_vld(smp_vld), .close(close),
        .term(q_inst), .total(q_sum)
    );

    pae_peak #(.SMP_W(SMP_W)) u_pk_v (
        .clk(clk), .rst(rst), .vld(smp_vld), .close(close),
        .smp(v_smp), .pk_total(vpk_tot)
    );

    pae_peak #(.SMP_W(SMP_W)) u_pk_i (
        .clk(clk), .rst(rst), .vld(smp_vld), .close(close),
        .smp(i_smp), .pk_total(ipk_tot)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b0;
        if (smp_vld) begin
            st_d.sh  = sh_eff;
            st_d.cnt = close ? '0 : st_q.cnt + 1'b1;
            if (close) begin
                st_d.avg_p = (PROD_W+1)'(PROD_W'(p_sum >>> sh_eff))
                           + (PROD_W+1)'(p_offset);
                st_d.avg_q = QPROD_W'(q_sum >>> sh_eff);
                st_d.vpk   = vpk_tot;
                st_d.ipk   = ipk_tot;
                st_d.rdy   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign avg_p   = st_q.avg_p;
    assign avg_q   = st_q.avg_q;
    assign v_peak  = st_q.vpk;
    assign i_peak  = st_q.ipk;
    assign res_rdy = st_q.rdy;

    // R7: a ready pulse is always caused by a sample on the previous edge
    p_rdy_cause_r7: assert property (@(posedge clk) disable iff (rst)
        res_rdy |-> $past(smp_vld));

    // R7: results hold whenever no update is signalled
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !res_rdy |-> ($stable(avg_p) && $stable(avg_q)
                      && $stable(v_peak) && $stable(i_peak)));

    // R9: an update coincides with the counter restarting
    p_rdy_restart_r9: assert property (@(posedge clk) disable iff (rst)
        res_rdy |-> (st_q.cnt == '0));

    // R3: a running count stays below the latched interval length
    p_cnt_in_n_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != '0) |-> ((CNT_W+1)'(st_q.cnt) < ((CNT_W+1)'(1) << st_q.sh)));
endmodule

// File: tb/pwr_accum_engine_tb.sv
module pwr_accum_engine_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic signed [15:0] vin = '0;
    logic signed [15:0] iin = '0;
    logic [3:0] nl = 4'd3;
    logic [15:0] epsw = 16'h8000;
    logic signed [31:0] poff = '0;
    logic signed [32:0] avg_p;
    logic signed [37:0] avg_q;
    logic [15:0] vpk, ipk;
    logic rdy;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // bench model state
    longint m_int, m_accp, m_accq, m_pkv, m_pki;
    int m_cnt, m_sh;
    longint exp_p, exp_q, exp_vpk, exp_ipk;
    bit exp_rdy;

    localparam logic signed [15:0] TV [8] = '{16'sd1000, -16'sd2000, 16'sd32767, 16'sh8000,
                                              16'sd5, 16'sd0, -16'sd12345, 16'sd20000};
    localparam logic signed [15:0] TI [8] = '{16'sd300, 16'sd300, -16'sd1, 16'sh8000,
                                              16'sd32767, 16'sd500, -16'sd7, -16'sd9999};

    always #2 clk = ~clk;

    pwr_accum_engine u_dut (
        .clk(clk), .rst(rst), .smp_vld(vld), .v_smp(vin), .i_smp(iin),
        .n_log2(nl), .eps(epsw), .p_offset(poff),
        .avg_p(avg_p), .avg_q(avg_q), .v_peak(vpk), .i_peak(ipk), .res_rdy(rdy)
    );

    task automatic chk(input string tag, input longint act, input longint expv);
        nchk++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_clear();
        m_int = 0; m_accp = 0; m_accq = 0; m_pkv = 0; m_pki = 0;
        m_cnt = 0; m_sh = 0;
        exp_p = 0; exp_q = 0; exp_vpk = 0; exp_ipk = 0; exp_rdy = 0;
    endtask

    task automatic model(input longint v, input longint i);
        longint vq;
        if (m_cnt == 0) m_sh = (nl > 12) ? 12 : int'(nl);
        m_int  = m_int + v - (m_int >>> 4);
        vq     = (m_int * longint'(epsw)) >>> 15;
        m_accp = m_accp + v * i;
        m_accq = m_accq + i * vq;
        if ((v < 0 ? -v : v) > m_pkv) m_pkv = (v < 0 ? -v : v);
        if ((i < 0 ? -i : i) > m_pki) m_pki = (i < 0 ? -i : i);
        if (m_cnt == (1 << m_sh) - 1) begin
            exp_p   = (m_accp >>> m_sh) + longint'(poff);
            exp_q   = m_accq >>> m_sh;
            exp_vpk = m_pkv;
            exp_ipk = m_pki;
            exp_rdy = 1;
            m_accp = 0; m_accq = 0; m_pkv = 0; m_pki = 0; m_cnt = 0;
        end else begin
            exp_rdy = 0;
            m_cnt++;
        end
    endtask

    task automatic outs(input string tag);
        chk({tag, " avg_p (R2)"}, avg_p, exp_p);
        chk({tag, " avg_q (R5 R4)"}, avg_q, exp_q);
        chk({tag, " v_peak (R6)"}, vpk, exp_vpk);
        chk({tag, " i_peak (R6)"}, ipk, exp_ipk);
    endtask

    task automatic smp(input logic signed [15:0] v, input logic signed [15:0] i, input string tag);
        @(negedge clk);
        vin = v; iin = i; vld = 1'b1;
        model(v, i);
        @(posedge clk);
        #1;
        vld = 1'b0;
        chk({tag, " res_rdy (R7)"}, rdy, exp_rdy);
        if (exp_rdy) outs(tag);
    endtask

    task automatic idle(input int n, input string tag);
        repeat (n) @(posedge clk);
        #1;
        chk({tag, " res_rdy idle (R7 R8)"}, rdy, 0);
        outs({tag, " hold R8"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        model_clear();
        do_reset();
        // R1: reset state
        chk("reset res_rdy R1", rdy, 0);
        outs("reset R1");

        // table walk: N = 8, unity gain trim, no offset
        nl = 4'd3; epsw = 16'h8000; poff = '0;
        for (int k = 0; k < 8; k++) smp(TV[k], TI[k], "table");
        chk("table v_peak full scale R6", vpk, 32768);
        chk("table i_peak full scale R6", ipk, 32768);
        idle(3, "after table");

        // second interval: new trim, gaps, offset cancels the previous mean
        epsw = 16'h6000;
        poff = 32'(-exp_p);
        smp(16'sd100, 16'sd200, "gap");
        idle(2, "gap");
        smp(-16'sd50, 16'sd40, "gap");
        smp(16'sd700, -16'sd90, "gap");
        idle(1, "gap");
        smp(-16'sd300, 16'sd11, "gap");
        smp(16'sd9, 16'sd9, "gap");
        smp(-16'sd1, -16'sd1234, "gap");
        smp(16'sd42, 16'sd17, "gap");
        poff = 32'sd777;    // R10: offset seen at the final sample is used
        smp(16'sd3, -16'sd3, "gap R9 R10");
        chk("gap v_peak from own interval R9", vpk, 700);

        // R3: change of N inside an interval applies later
        nl = 4'd2;
        smp(16'sd1200, 16'sd33, "nchg R3");
        nl = 4'd0;
        smp(-16'sd77, 16'sd5, "nchg R3");
        smp(16'sd88, 16'sd61, "nchg R3");
        smp(16'sd5, -16'sd400, "nchg R3");
        chk("nchg rdy at fourth sample R3", rdy, 1);
        // N = 1 gives a result per sample
        smp(16'sd7, -16'sd3, "n1 R3");
        smp(-16'sd19, 16'sd23, "n1 R3");
        chk("n1 avg_p R3", avg_p, -437 + 777);

        // R11: clamp to 4096, full-scale sums
        nl = 4'd15; poff = '0; epsw = 16'hffff;
        for (int k = 0; k < 4096; k++) smp(16'sh8000, 16'sh8000, "fs");
        chk("fs avg_p 2^30 R11", avg_p, 64'sd1073741824);
        chk("fs i_peak R11 R6", ipk, 32768);

        // R1: reset part way through an interval
        nl = 4'd2; epsw = 16'h8000;
        smp(16'sd500, 16'sd500, "mid");
        smp(16'sd600, 16'sd600, "mid");
        do_reset();
        chk("mid reset res_rdy R1", rdy, 0);
        outs("mid reset R1");
        smp(16'sd10, 16'sd20, "post");
        smp(-16'sd30, 16'sd40, "post");
        smp(16'sd50, -16'sd60, "post");
        smp(16'sd70, 16'sd80, "post R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule